// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is the control core of a byte-wide nonvolatile store with a parallel, active-low bus. A host writes by pulling both chip select and write strobe low while output enable is high. Whichever of the two goes low later opens the strobe. The controller takes the address when a strobe is accepted and takes the data when the strobe closes. It gathers the bytes of one page in a local buffer. When no strobe has begun for a set number of cycles, it stops accepting bytes and runs an internal program cycle. That cycle moves every buffered byte into a behavioural array.

All bus controls pass through a two-stage synchroniser. A filter then rejects strobes that are too short. Every time limit is a parameter counted in clock cycles: the pulse filter, the maximum spacing between byte strobes, the idle window that starts programming, and the length of the program cycle. The `busy` output is high for exactly the program cycle. An active-low protect input blocks reads and writes, and pulling it low during programming aborts the commit.

Top module: `pgw_ctrl`

## Requirements
- R1: One load sequence may carry any number of bytes from 1 to 2**PAGE_W into a single page. When the page is committed, each loaded offset receives its last loaded byte. Offsets that were not loaded keep their previous contents. The array reads as zero after `rst_n`.
- R2: The page number is `addr[ADDR_W-1:PAGE_W]`, captured when the first strobe of a sequence is accepted. For every later byte of that sequence, only `addr[PAGE_W-1:0]` is used.
- R3: A write strobe is active while `ce_n` and `we_n` are both low, `oe_n` is high and `res_n` is high. Either control may fall last. The address is taken when the strobe is accepted, and `din` is taken when the strobe ends.
- R4: A strobe seen active for fewer than FILT_CYC consecutive synchronised cycles has no effect.
- R5: A strobe that is accepted more than BLC_CYC cycles after the previous accepted strobe of the same sequence is discarded, and its byte is not stored.
- R6: Programming starts once WIN_CYC cycles have passed since the last accepted strobe and no strobe is active. `busy` is then high for exactly PROG_CYC cycles, and is never high without a loaded sequence.
- R7: With `oe_n` low, `ce_n` and `we_n` low together do not write.
- R8: Strobes that arrive while `busy` is high do not change the buffered page, do not store a byte and do not start a new sequence.
- R9: While `res_n` is low, reads and strobes are blocked and any loaded bytes are dropped. A fall of `res_n` during programming ends `busy`. Bytes are moved into the array only in the last 2**PAGE_W cycles of the program cycle, so an abort before that point leaves the array unchanged.
- R10: `dout_vld` goes high, with `dout` equal to the array byte at `addr`, when `ce_n` and `oe_n` are low, `we_n` is high, `res_n` is high and `busy` is low. Otherwise `dout_vld` is low.
- R11: After reset, `busy` and `dout_vld` are low and no sequence is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| res_n | input | 1 | Protect input, active low: blocks access and aborts programming |
| addr | input | ADDR_W | Byte address; the upper bits select the page |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_vld | output | 1 | Read data valid |
| busy | output | 1 | High during the internal program cycle |

## Verification
The assertions check several properties on every cycle. The page number stays fixed while a sequence is open. The buffer stays frozen while programming runs. No byte can land once the spacing limit has passed. `busy` always rises out of an expired idle window and falls either after the full program length or because of the protect input. Read data is never valid during programming. Other behaviours can only be shown by the bench scenarios, which read the array back through the bus afterwards. These include the pulse filter, the output-enable inhibit, both strobe orders, the partial-page merge, the full-page load and the unchanged array after an early abort.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOAD = 2'd1,
        PG_PROG = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgw_sync.sv
// Two-flop synchroniser for a vector of active-low controls (reset to inactive).
module pgw_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/pgw_strobe.sv
// Pulse-width filter: a strobe counts only after FILT_CYC consecutive active cycles.
module pgw_strobe #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } stb_t;

    stb_t q, d;

    always_comb begin
        d      = q;
        fall_o = act_i && !q.armed && (q.cnt == LAST);
        rise_o = !act_i && q.armed;
        if (act_i) begin
            if (q.cnt != LAST) d.cnt = q.cnt + 1'b1;
            if (fall_o)        d.armed = 1'b1;
        end else begin
            d.cnt   = '0;
            d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pgw_mem.sv
// Behavioural byte array: one write port, one registered read port.
module pgw_mem #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvld_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;
    logic              rvld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rdata_q <= '0;
            rvld_q  <= 1'b0;
        end else begin
            if (we_i) mem_q[waddr_i] <= wdata_i;
            rvld_q  <= rd_i;
            rdata_q <= rd_i ? mem_q[raddr_i] : '0;
        end
    end

    assign rdata_o = rdata_q;
    assign rvld_o  = rvld_q;
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 7,
    parameter int FILT_CYC = 3,
    parameter int BLC_CYC  = 3750,
    parameter int WIN_CYC  = 12500,
    parameter int PROG_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              res_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              busy
);
    import pgw_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_AW      = ADDR_W - PAGE_W;
    localparam int GAP_W      = $clog2(WIN_CYC + 1);
    localparam int PRG_W      = $clog2(PROG_CYC + 1);
    localparam logic [GAP_W-1:0] WIN_L  = GAP_W'(WIN_CYC);
    localparam logic [GAP_W-1:0] BLC_L  = GAP_W'(BLC_CYC);
    localparam logic [PRG_W-1:0] PEND_L = PRG_W'(PROG_CYC - 1);
    localparam logic [PRG_W-1:0] CST_L  = PRG_W'(PROG_CYC - PAGE_BYTES);

    typedef struct packed {
        pg_state_e                            st;
        logic [PG_AW-1:0]                     page;
        logic [PAGE_W-1:0]                    off;
        logic                                 take;
        logic [GAP_W-1:0]                     gap;
        logic [PRG_W-1:0]                     prog;
        logic [PAGE_BYTES-1:0]                vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]    pbuf;
    } seq_t;

    seq_t q, d;

    logic [3:0]        ctl_s;
    logic              ce_s, we_s, oe_s, res_s;
    logic              act, fall, rise, rd_en;
    logic              mem_we;
    logic [PAGE_W-1:0] cidx;

    pgw_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ce_n, we_n, oe_n, res_n}),
        .q_o   (ctl_s)
    );

    assign {ce_s, we_s, oe_s, res_s} = ctl_s;
    assign act   = !ce_s && !we_s && oe_s && res_s;
    assign rd_en = !ce_s && !oe_s && we_s && res_s && (q.st != PG_PROG);
    assign busy  = (q.st == PG_PROG);
    assign cidx  = PAGE_W'(q.prog - CST_L);

    pgw_strobe #(.FILT_CYC(FILT_CYC)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .fall_o (fall),
        .rise_o (rise)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (!res_s) begin
            d.st   = PG_IDLE;
            d.take = 1'b0;
            d.vld  = '0;
            d.gap  = '0;
            d.prog = '0;
        end else begin
            unique case (q.st)
                PG_IDLE: begin
                    if (fall) begin
                        d.st   = PG_LOAD;
                        d.page = addr[ADDR_W-1:PAGE_W];
                        d.off  = addr[PAGE_W-1:0];
                        d.take = 1'b1;
                        d.gap  = '0;
                    end
                end
                PG_LOAD: begin
                    if (q.gap != WIN_L) d.gap = q.gap + 1'b1;
                    if (fall) begin
                        if (q.gap <= BLC_L) begin
                            d.off  = addr[PAGE_W-1:0];
                            d.take = 1'b1;
                            d.gap  = '0;
                        end
                    end else if (rise) begin
                        if (q.take) begin
                            d.pbuf[q.off] = din;
                            d.vld[q.off]  = 1'b1;
                        end
                        d.take = 1'b0;
                    end else if (q.gap == WIN_L && !act && !q.take) begin
                        d.st   = PG_PROG;
                        d.prog = '0;
                    end
                end
                PG_PROG: begin
                    d.prog = q.prog + 1'b1;
                    if (q.prog >= CST_L) mem_we = q.vld[cidx];
                    if (q.prog == PEND_L) begin
                        d.st   = PG_IDLE;
                        d.vld  = '0;
                        d.take = 1'b0;
                    end
                end
                default: d.st = PG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    pgw_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i ({q.page, cidx}),
        .wdata_i (q.pbuf[cidx]),
        .rd_i    (rd_en),
        .raddr_i (addr),
        .rdata_o (dout),
        .rvld_o  (dout_vld)
    );

    // R2
    page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PG_LOAD && $past(q.st) == PG_LOAD) |-> $stable(q.page));

    // R5
    late_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PG_LOAD && q.gap > BLC_L && !q.take && res_s) |=> $stable(q.vld));

    // R6
    prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.gap) == WIN_L);

    // R6
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(res_s)) |-> $past(q.prog) == PEND_L);

    // R8
    buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PG_PROG && $past(q.st) == PG_PROG) |-> ($stable(q.vld) && $stable(q.pbuf)));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_s) |=> !busy);

    // R10
    no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> !$past(busy));
endmodule

// File: tb/pgw_ctrl_bench.sv
module pgw_ctrl_bench;
    localparam int ADDR_W = 9;
    localparam int PAGE_W = 7;
    localparam int FILT   = 3;
    localparam int BLC    = 40;
    localparam int WIN    = 120;
    localparam int PROG   = 400;
    localparam int M      = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ce_n, we_n, oe_n, res_n;
    logic [ADDR_W-1:0] addr;
    logic [7:0] din, dout;
    logic dout_vld, busy;

    pgw_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(8), .PAGE_W(PAGE_W), .FILT_CYC(FILT),
        .BLC_CYC(BLC), .WIN_CYC(WIN), .PROG_CYC(PROG)
    ) u_pgw_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .res_n(res_n), .addr(addr), .din(din), .dout(dout),
        .dout_vld(dout_vld), .busy(busy)
    );

    int vec = 0;
    int bad = 0;
    int cyc = 0;
    int t_lo = 0;
    int unk_until = 0;
    int page_sel = 0;
    bit pending = 1'b0;
    logic [7:0] ref_mem [1 << ADDR_W];
    int q_addr[$];
    int q_dat[$];

    function automatic void chk(bit ok, string req, int act, int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // cycle-by-cycle busy model, driven from the bench's own strobe timeline
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cyc >= unk_until) begin
            if (pending) begin
                int dl;
                dl = cyc - t_lo;
                if (dl < WIN)
                    chk(busy == 1'b0, "R6 busy low inside load window", busy, 0);
                else if (dl >= WIN + M && dl < WIN + PROG)
                    chk(busy == 1'b1, "R6 busy high during program", busy, 1);
                else if (dl >= WIN + PROG + M) begin
                    chk(busy == 1'b0, "R6 busy low after program", busy, 0);
                    if (dl >= WIN + PROG + 2 * M) pending = 1'b0;
                end
            end else begin
                chk(busy == 1'b0, "R6 no program without accepted byte", busy, 0);
            end
        end
    end

    task automatic put(int a, int dt, bit ce_last, bit take);
        @(negedge clk);
        addr = ADDR_W'(a);
        din  = 8'(dt);
        oe_n = 1'b1;
        if (ce_last) we_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        if (ce_last) ce_n = 1'b0; else we_n = 1'b0;
        if (take) begin
            if (q_addr.size() == 0) page_sel = a >> PAGE_W;
            q_addr.push_back((page_sel << PAGE_W) | (a & ((1 << PAGE_W) - 1)));
            q_dat.push_back(dt & 8'hFF);
            t_lo    = cyc;
            pending = 1'b1;
        end
        repeat (6) @(negedge clk);
        if (ce_last) ce_n = 1'b1; else we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
    endtask

    task automatic finish_seq();
        wait (pending == 1'b0);
        foreach (q_addr[i]) ref_mem[q_addr[i]] = 8'(q_dat[i]);
        q_addr.delete();
        q_dat.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(int a, string req);
        @(negedge clk);
        addr = ADDR_W'(a);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(dout_vld === 1'b1 && dout === ref_mem[a], req,
            {dout_vld, dout}, {1'b1, ref_mem[a]});
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_blk(int a, string req);
        @(negedge clk);
        addr = ADDR_W'(a);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(dout_vld === 1'b0, req, dout_vld, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        foreach (ref_mem[i]) ref_mem[i] = 8'h00;
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; res_n = 1'b1;
        addr = '0; din = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0 && dout_vld == 1'b0, "R11 reset state", {busy, dout_vld}, 0);
        rd(9'h085, "R11 array clear after reset");

        // R3 single byte, write strobe falls last
        put(9'h085, 8'h3C, 1'b0, 1'b1);
        finish_seq();
        rd(9'h085, "R3 byte via write-strobe-last");
        rd(9'h086, "R1 unloaded neighbour");

        // R2 page frozen, chip select falls last (R3), partial page merge (R1)
        put(9'h0A0, 8'h11, 1'b1, 1'b1);
        put(9'h1A1, 8'h22, 1'b1, 1'b1);
        put(9'h0A2, 8'h33, 1'b0, 1'b1);
        finish_seq();
        rd(9'h0A0, "R3 byte via chip-select-last");
        rd(9'h0A1, "R2 later byte lands in first page");
        rd(9'h1A1, "R2 other page untouched");
        rd(9'h0A2, "R1 third byte");
        rd(9'h085, "R1 earlier byte kept");

        // R4 one-cycle glitch
        @(negedge clk);
        addr = 9'h010; din = 8'hEE; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        repeat (3) @(negedge clk); ce_n = 1'b1;
        repeat (200) @(negedge clk);
        rd(9'h010, "R4 short pulse ignored");

        // R7 write with output enable low
        @(negedge clk);
        addr = 9'h011; din = 8'h77; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (8) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (200) @(negedge clk);
        rd(9'h011, "R7 output enable low inhibits");

        // R5 late byte
        put(9'h100, 8'h5A, 1'b0, 1'b1);
        repeat (45) @(negedge clk);
        put(9'h101, 8'h77, 1'b0, 1'b0);
        finish_seq();
        rd(9'h100, "R5 timely byte stored");
        rd(9'h101, "R5 late byte dropped");

        // R8 strobe during program, R10 read blocked while busy
        put(9'h180, 8'h99, 1'b0, 1'b1);
        while (!busy) @(negedge clk);
        repeat (10) @(negedge clk);
        put(9'h181, 8'h44, 1'b1, 1'b0);
        rd_blk(9'h180, "R10 read blocked while busy");
        finish_seq();
        repeat (200) @(negedge clk);
        rd(9'h180, "R8 page committed");
        rd(9'h181, "R8 strobe during program ignored");

        // R9 abort before commit phase
        put(9'h020, 8'hAB, 1'b0, 1'b1);
        while (!busy) @(negedge clk);
        repeat (20) @(negedge clk);
        res_n     = 1'b0;
        pending   = 1'b0;
        unk_until = cyc + 8;
        q_addr.delete();
        q_dat.delete();
        repeat (10) @(negedge clk);
        rd_blk(9'h085, "R9 read blocked under protect");
        put(9'h021, 8'h12, 1'b0, 1'b0);
        repeat (200) @(negedge clk);
        res_n = 1'b1;
        repeat (5) @(negedge clk);
        rd(9'h020, "R9 aborted page not committed");
        rd(9'h021, "R9 strobe under protect ignored");

        // R1 full page, alternating strobe order
        for (int i = 0; i < (1 << PAGE_W); i++)
            put(9'h180 + i, (i * 7 + 3) & 8'hFF, i[0], 1'b1);
        finish_seq();
        for (int i = 0; i < (1 << PAGE_W); i++)
            rd(9'h180 + i, "R1 full page");

        summary();
        $finish;
    end
endmodule